// File: doc/BRIEF.md
# Run-Gated Configuration Register Bank

This block is a small bank of configuration registers behind a simple register-access bus: an address, a write strobe, a read strobe, write data and combinational read data. A host, usually reached through a serial front end, programs the configuration registers and then sets a run bit in a control register. That bit drives a monitor-enable output, which starts the sensing activity elsewhere on the chip.

While the run bit is set, the bank freezes its settings. The configuration registers ignore writes, and so do the option bits of the control register. Some things stay open: the run, CRC-request and soft-reset bits of the control register, and one register reserved for polling settings. A write that the freeze refuses sets a sticky error flag, and reading the status register clears it. To change the settings, the host clears the run bit, writes the new values and sets the run bit again.

A CRC check can be asked for at any time. Writing the CRC-request bit produces a one-cycle pulse for the checker, which lives outside this block.

Top module: `cfg_lock_regbank`

## Requirements
- R1: One clock after a write to address 0, `mon_en` equals bit 0 (the run bit) of the written data, unless bit 2 of that data is 1.
- R2: While the run bit is 1, a write to a configuration address (1 to NUM_CFG) other than the polling register leaves that register unchanged.
- R3: Bits 0 (run), 1 (CRC request) and 2 (soft reset) of address 0 take effect on a write whether the run bit is 0 or 1.
- R4: The polling register, at address POLL_IDX+1 (4 by default), accepts writes while the run bit is 1 and raises no error.
- R5: While the run bit is 0, every configuration register accepts writes, and so do the option bits [7:3] of address 0. Address 0 reads as {option, 0, 0, run}.
- R6: Writing 1 to bit 1 of address 0 drives `crc_req` high for exactly the following cycle, at any run state. Bit 1 always reads back as 0.
- R7: Writing 1 to bit 2 of address 0 clears, at the next clock, every register: the run bit, the option bits, the configuration registers and the error flag. No CRC pulse is emitted for that write, and bit 2 reads back as 0.
- R8: A write refused by the lock sets bit 0 of the status register at address NUM_CFG+1. The flag stays set until the status register is read. That read returns 1 and clears the flag.
- R9: Reads are never locked. Every mapped register returns its current value while the run bit is 1.
- R10: A write to address 0 while the run bit is already 1 keeps the old option bits. If the written option bits differ from the stored ones, the write counts as refused.
- R11: Addresses above NUM_CFG+1 read as 0. Writes to them change no register and set no error.
- R12: After `rst_n` is released, all registers read 0 and `mon_en` and `crc_req` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_addr | input | ADDR_W | Register address |
| acc_wr | input | 1 | Write strobe, one cycle per write |
| acc_rd | input | 1 | Read strobe; a status read clears the error flag |
| acc_wdata | input | DATA_W | Write data |
| acc_rdata | output | DATA_W | Combinational read data for `acc_addr` |
| mon_en | output | 1 | Monitor enable, equal to the run bit |
| crc_req | output | 1 | One-cycle CRC request pulse |
| ctrl_opt | output | DATA_W-3 | Option bits of the control register |
| cfg_flat | output | NUM_CFG*DATA_W | Configuration registers packed, register 0 in the low bits |

## Verification
The properties assume that at most one of `acc_wr` and `acc_rd` is high in a cycle, and that address and data are stable around the clock edge that commits an access. The bench keeps to this. Every access lasts exactly one cycle, with inputs changed on the falling edge, and the two strobes are never raised together. The bench never writes the CRC-request bit in two consecutive cycles, so a pulse can always be traced back to the single write that caused it.

// File: rtl/cfgl_pkg.sv
package cfgl_pkg;
   localparam int CTRL_RUN     = 0;
   localparam int CTRL_CRC     = 1;
   localparam int CTRL_RST     = 2;
   localparam int CTRL_OPT_LSB = 3;

   typedef enum logic [1:0] {
      ACC_NONE,
      ACC_CTRL,
      ACC_CFG,
      ACC_STAT
   } acc_cls_e;
endpackage

// File: rtl/cfgl_decode.sv
module cfgl_decode #(
   parameter int ADDR_W  = 3,
   parameter int NUM_CFG = 4,
   parameter int IDX_W   = 2
) (
   input  logic [ADDR_W-1:0]  addr,
   output cfgl_pkg::acc_cls_e cls,
   output logic [IDX_W-1:0]   idx
);
   import cfgl_pkg::*;

   localparam logic [ADDR_W-1:0] A_LAST = ADDR_W'(NUM_CFG);
   localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(NUM_CFG + 1);

   always_comb begin
      idx = IDX_W'(addr - ADDR_W'(1));
      if (addr == '0)          cls = ACC_CTRL;
      else if (addr <= A_LAST) cls = ACC_CFG;
      else if (addr == A_STAT) cls = ACC_STAT;
      else                     cls = ACC_NONE;
   end
endmodule

// File: rtl/cfgl_lock_policy.sv
module cfgl_lock_policy #(
   parameter int NUM_CFG  = 4,
   parameter int POLL_IDX = 3,
   parameter int IDX_W    = 2
) (
   input  logic               run,
   input  logic               wr,
   input  cfgl_pkg::acc_cls_e cls,
   input  logic [IDX_W-1:0]   idx,
   input  logic               opt_diff,
   output logic [NUM_CFG-1:0] cfg_we,
   output logic               ctrl_we,
   output logic               opt_we,
   output logic               lock_err
);
   import cfgl_pkg::*;

   logic cfg_hit;
   assign cfg_hit = wr && (cls == ACC_CFG);

   for (genvar g = 0; g < NUM_CFG; g++) begin : g_we
      if (g == POLL_IDX) begin : g_free
         assign cfg_we[g] = cfg_hit && (idx == IDX_W'(g));
      end else begin : g_lock
         assign cfg_we[g] = cfg_hit && (idx == IDX_W'(g)) && !run;
      end
   end

   assign ctrl_we  = wr && (cls == ACC_CTRL);
   assign opt_we   = ctrl_we && !run;
   assign lock_err = run && ((cfg_hit && (idx != IDX_W'(POLL_IDX)))
                             || (ctrl_we && opt_diff));
endmodule

// File: rtl/cfgl_cfg_reg.sv
module cfgl_cfg_reg #(
   parameter int                DATA_W  = 8,
   parameter logic [DATA_W-1:0] RST_VAL = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              we,
   input  logic [DATA_W-1:0] d,
   output logic [DATA_W-1:0] q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   q <= RST_VAL;
      else if (clr) q <= RST_VAL;
      else if (we)  q <= d;
   end
endmodule

// File: rtl/cfg_lock_regbank.sv
module cfg_lock_regbank #(
   parameter int DATA_W   = 8,
   parameter int ADDR_W   = 3,
   parameter int NUM_CFG  = 4,
   parameter int POLL_IDX = 3
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [ADDR_W-1:0]         acc_addr,
   input  logic                      acc_wr,
   input  logic                      acc_rd,
   input  logic [DATA_W-1:0]         acc_wdata,
   output logic [DATA_W-1:0]         acc_rdata,
   output logic                      mon_en,
   output logic                      crc_req,
   output logic [DATA_W-4:0]         ctrl_opt,
   output logic [NUM_CFG*DATA_W-1:0] cfg_flat
);
   import cfgl_pkg::*;

   localparam int IDX_W = (NUM_CFG > 1) ? $clog2(NUM_CFG) : 1;
   localparam int OPT_W = DATA_W - CTRL_OPT_LSB;

   if (DATA_W < 4) begin : g_chk_width
      $error("DATA_W must leave at least one option bit");
   end
   if (POLL_IDX >= NUM_CFG) begin : g_chk_poll
      $error("POLL_IDX must select an existing register");
   end
   if (NUM_CFG + 2 > (1 << ADDR_W)) begin : g_chk_map
      $error("ADDR_W too small for the register map");
   end

   acc_cls_e           cls;
   logic [IDX_W-1:0]   cfg_idx;
   logic [NUM_CFG-1:0] cfg_we;
   logic               ctrl_we, opt_we, lock_err, opt_diff, soft_rst;
   logic               run_q, crc_q, err_q;
   logic [OPT_W-1:0]   opt_q;

   cfgl_decode #(.ADDR_W(ADDR_W), .NUM_CFG(NUM_CFG), .IDX_W(IDX_W)) u_dec (
      .addr(acc_addr), .cls(cls), .idx(cfg_idx)
   );

   assign opt_diff = acc_wdata[DATA_W-1:CTRL_OPT_LSB] != opt_q;

   cfgl_lock_policy #(.NUM_CFG(NUM_CFG), .POLL_IDX(POLL_IDX), .IDX_W(IDX_W)) u_pol (
      .run(run_q), .wr(acc_wr), .cls(cls), .idx(cfg_idx), .opt_diff(opt_diff),
      .cfg_we(cfg_we), .ctrl_we(ctrl_we), .opt_we(opt_we), .lock_err(lock_err)
   );

   assign soft_rst = ctrl_we && acc_wdata[CTRL_RST];

   for (genvar i = 0; i < NUM_CFG; i++) begin : g_cfg
      cfgl_cfg_reg #(.DATA_W(DATA_W)) u_reg (
         .clk(clk), .rst_n(rst_n), .clr(soft_rst), .we(cfg_we[i]),
         .d(acc_wdata), .q(cfg_flat[i*DATA_W +: DATA_W])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q <= 1'b0;
         crc_q <= 1'b0;
         err_q <= 1'b0;
         opt_q <= '0;
      end else if (soft_rst) begin
         run_q <= 1'b0;
         crc_q <= 1'b0;
         err_q <= 1'b0;
         opt_q <= '0;
      end else begin
         crc_q <= ctrl_we && acc_wdata[CTRL_CRC];
         if (ctrl_we) run_q <= acc_wdata[CTRL_RUN];
         if (opt_we)  opt_q <= acc_wdata[DATA_W-1:CTRL_OPT_LSB];
         if (lock_err)                          err_q <= 1'b1;
         else if (acc_rd && (cls == ACC_STAT))  err_q <= 1'b0;
      end
   end

   always_comb begin
      unique case (cls)
         ACC_CTRL: acc_rdata = {opt_q, 2'b00, run_q};
         ACC_CFG:  acc_rdata = cfg_flat[cfg_idx*DATA_W +: DATA_W];
         ACC_STAT: acc_rdata = {{(DATA_W-1){1'b0}}, err_q};
         default:  acc_rdata = '0;
      endcase
   end

   assign mon_en   = run_q;
   assign crc_req  = crc_q;
   assign ctrl_opt = opt_q;
endmodule

// File: rtl/cfgl_checker.sv
module cfgl_checker #(
   parameter int DATA_W   = 8,
   parameter int ADDR_W   = 3,
   parameter int NUM_CFG  = 4,
   parameter int POLL_IDX = 3
) (
   input logic                      clk,
   input logic                      rst_n,
   input logic [ADDR_W-1:0]         acc_addr,
   input logic                      acc_wr,
   input logic                      acc_rd,
   input logic [DATA_W-1:0]         acc_wdata,
   input logic [DATA_W-1:0]         acc_rdata,
   input logic                      mon_en,
   input logic                      crc_req,
   input logic [DATA_W-4:0]         ctrl_opt,
   input logic [NUM_CFG*DATA_W-1:0] cfg_flat
);
   localparam logic [ADDR_W-1:0] A_CTRL  = '0;
   localparam logic [ADDR_W-1:0] A_FIRST = ADDR_W'(1);
   localparam logic [ADDR_W-1:0] A_LAST  = ADDR_W'(NUM_CFG);
   localparam logic [ADDR_W-1:0] A_POLL  = ADDR_W'(POLL_IDX + 1);
   localparam logic [ADDR_W-1:0] A_STAT  = ADDR_W'(NUM_CFG + 1);

   logic ctrl_wr, cfg_locked_wr;
   assign ctrl_wr       = acc_wr && (acc_addr == A_CTRL);
   assign cfg_locked_wr = acc_wr && (acc_addr >= A_FIRST) && (acc_addr <= A_LAST)
                          && (acc_addr != A_POLL);

   AST_RUN_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_wr && !acc_wdata[2]) |=> (mon_en == $past(acc_wdata[0]))); // R1
   AST_LOCKED_CFG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (mon_en && cfg_locked_wr) |=> $stable(cfg_flat)); // R2
   AST_POLL_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_wr && (acc_addr == A_POLL))
      |=> (cfg_flat[POLL_IDX*DATA_W +: DATA_W] == $past(acc_wdata))); // R4
   AST_CRC_FIRES: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_wr && acc_wdata[1] && !acc_wdata[2]) |=> crc_req); // R6
   AST_CRC_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      crc_req |-> $past(ctrl_wr && acc_wdata[1] && !acc_wdata[2])); // R6
   AST_SOFT_RESET: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_wr && acc_wdata[2])
      |=> (!mon_en && !crc_req && (cfg_flat == '0) && (ctrl_opt == '0))); // R7
   AST_OPT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      (mon_en && ctrl_wr && !acc_wdata[2]) |=> $stable(ctrl_opt)); // R10
   AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_rd && (acc_addr > A_STAT)) |-> (acc_rdata == '0)); // R11
endmodule

bind cfg_lock_regbank cfgl_checker #(
   .DATA_W(DATA_W), .ADDR_W(ADDR_W), .NUM_CFG(NUM_CFG), .POLL_IDX(POLL_IDX)
) u_chk (
   .clk(clk), .rst_n(rst_n), .acc_addr(acc_addr), .acc_wr(acc_wr), .acc_rd(acc_rd),
   .acc_wdata(acc_wdata), .acc_rdata(acc_rdata), .mon_en(mon_en), .crc_req(crc_req),
   .ctrl_opt(ctrl_opt), .cfg_flat(cfg_flat)
);

// File: tb/test_cfg_lock_regbank.sv
module test_cfg_lock_regbank;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [2:0] acc_addr = '0;
   logic       acc_wr = 1'b0;
   logic       acc_rd = 1'b0;
   logic [7:0] acc_wdata = '0;
   logic [7:0] acc_rdata;
   logic       mon_en, crc_req;
   logic [4:0] ctrl_opt;
   logic [31:0] cfg_flat;

   int vecs = 0;
   int miss = 0;

   typedef struct {
      logic [7:0] exp;
      string      tag;
   } exp_t;
   exp_t sb_q[$];

   always #5 clk = ~clk;

   cfg_lock_regbank i_cfg_lock_regbank (
      .clk(clk), .rst_n(rst_n), .acc_addr(acc_addr), .acc_wr(acc_wr), .acc_rd(acc_rd),
      .acc_wdata(acc_wdata), .acc_rdata(acc_rdata), .mon_en(mon_en), .crc_req(crc_req),
      .ctrl_opt(ctrl_opt), .cfg_flat(cfg_flat)
   );

   task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
      vecs++;
      if (act !== exp) begin
         miss++;
         $display("FAIL %s: got %h expected %h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [7:0] d);
      @(negedge clk);
      acc_addr = a; acc_wdata = d; acc_wr = 1'b1; acc_rd = 1'b0;
      @(negedge clk);
      acc_wr = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, input logic [7:0] e, input string tag);
      @(negedge clk);
      acc_addr = a; acc_rd = 1'b1; acc_wr = 1'b0;
      sb_q.push_back('{exp: e, tag: tag});
      @(negedge clk);
      acc_rd = 1'b0;
   endtask

   // monitor: pops the expected read data for every read cycle
   initial begin
      forever begin
         @(negedge clk);
         #2;
         if (acc_rd) begin
            if (sb_q.size() == 0) check("scoreboard empty", 8'hxx, 8'h00);
            else begin
               exp_t it;
               it = sb_q.pop_front();
               check(it.tag, acc_rdata, it.exp);
            end
         end
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      miss++; vecs++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R12 mon_en after reset", {7'd0, mon_en}, 8'h00);
      check("R12 crc_req after reset", {7'd0, crc_req}, 8'h00);
      rd(3'd0, 8'h00, "R12 control reset");
      for (int i = 1; i <= 4; i++) rd(3'(i), 8'h00, "R12 config reset");
      rd(3'd5, 8'h00, "R12 status reset");

      // unlocked programming
      wr(3'd1, 8'hA1); wr(3'd2, 8'hB2); wr(3'd3, 8'hC3); wr(3'd4, 8'h44);
      rd(3'd1, 8'hA1, "R5 cfg1"); rd(3'd2, 8'hB2, "R5 cfg2");
      rd(3'd3, 8'hC3, "R5 cfg3"); rd(3'd4, 8'h44, "R5 cfg4");
      wr(3'd0, 8'hA8);
      rd(3'd0, 8'hA8, "R5 control options");
      check("R5 ctrl_opt port", {3'd0, ctrl_opt}, 8'h15);
      check("R1 mon_en still low", {7'd0, mon_en}, 8'h00);

      // start run
      wr(3'd0, 8'hA9);
      check("R1 mon_en set", {7'd0, mon_en}, 8'h01);
      rd(3'd0, 8'hA9, "R9 control read while running");

      // locked writes
      wr(3'd2, 8'h55);
      rd(3'd2, 8'hB2, "R2 locked cfg2 unchanged");
      wr(3'd1, 8'h11);
      rd(3'd3, 8'hC3, "R9 cfg3 readable while locked");
      rd(3'd1, 8'hA1, "R2 locked cfg1 unchanged");
      rd(3'd5, 8'h01, "R8 error flag sticky");
      rd(3'd5, 8'h00, "R8 error flag cleared by read");

      // exempt polling register
      wr(3'd4, 8'h99);
      rd(3'd4, 8'h99, "R4 polling register written");
      rd(3'd5, 8'h00, "R4 no error for polling write");

      // mixed control write under lock
      wr(3'd0, 8'h19);
      rd(3'd0, 8'hA9, "R10 options kept");
      check("R10 ctrl_opt port", {3'd0, ctrl_opt}, 8'h15);
      rd(3'd5, 8'h01, "R10 option change refused");

      // CRC request while running
      wr(3'd0, 8'hAB);
      check("R6 crc pulse high", {7'd0, crc_req}, 8'h01);
      @(negedge clk);
      check("R6 crc pulse one cycle", {7'd0, crc_req}, 8'h00);
      rd(3'd0, 8'hA9, "R6 crc bit reads zero");
      rd(3'd5, 8'h00, "R3 crc write not refused");

      // unmapped addresses
      wr(3'd6, 8'hFF);
      rd(3'd6, 8'h00, "R11 unmapped 6 reads zero");
      rd(3'd7, 8'h00, "R11 unmapped 7 reads zero");
      rd(3'd5, 8'h00, "R11 no error on unmapped write");
      rd(3'd1, 8'hA1, "R11 cfg1 untouched");
      rd(3'd4, 8'h99, "R11 cfg4 untouched");

      // stop run, reconfigure
      wr(3'd0, 8'hA8);
      check("R3 run cleared under lock", {7'd0, mon_en}, 8'h00);
      wr(3'd2, 8'h66);
      rd(3'd2, 8'h66, "R5 cfg2 writable after stop");

      // soft reset while running, with pending error and crc bit
      wr(3'd0, 8'hA9);
      wr(3'd1, 8'h77);
      wr(3'd0, 8'hAF);
      check("R7 mon_en cleared", {7'd0, mon_en}, 8'h00);
      check("R7 no crc pulse", {7'd0, crc_req}, 8'h00);
      rd(3'd0, 8'h00, "R7 control cleared");
      for (int i = 1; i <= 4; i++) rd(3'(i), 8'h00, "R7 config cleared");
      rd(3'd5, 8'h00, "R7 error cleared");
      check("R7 ctrl_opt cleared", {3'd0, ctrl_opt}, 8'h00);
      wr(3'd3, 8'h3C);
      rd(3'd3, 8'h3C, "R5 writable after soft reset");

      repeat (3) @(negedge clk);
      if (sb_q.size() != 0) check("scoreboard drained", 8'(sb_q.size()), 8'h00);
      $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
      $finish;
   end
endmodule